// File: doc/BRIEF.md
# Frame-Aligned Transmit Buffer Reader

This block sits between a circular sample buffer and a framed serial link transmitter. A free-running frame position count arrives from the framer and is compared every cycle against two programmable positions. When the position equals the write-start position, the writer side is allowed into the buffer and its write address restarts at zero. When the position equals the map position, the read address and the container index K both return to zero, and from then on the block reads one word per transmit slot and presents it, tagged with its K value, as a valid/data pair.

The buffer RAM lives outside the block. It has one write port and one read port, and a read returns its data one cycle after the request. The block drives both ports through registered outputs. It keeps a saturating fill count between the two sides. A write into a full buffer or a read from an empty one raises a sticky status bit, but the access still goes ahead. A configuration flag warns when the write-start position does not come strictly before the map position.

Top module: `fatx_txbuf_reader`

## Requirements
- R1: In a cycle where `frame_pos` equals `map_ofs` and `tx_slot` is high, the next cycle shows `mem_re`=1 and `mem_raddr`=0. The match also arms the read side, which stays armed until reset.
- R2: The container index is cleared on a map match. The word read in the match cycle carries K=0, and each later word carries the previous K plus one, wrapping from K_LEN-1 to 0.
- R3: In a cycle where `frame_pos` equals `wstart_ofs` and `wr_en` is high, the next cycle shows `mem_we`=1, `mem_waddr`=0 and `mem_wdata` equal to that `wr_data`. Writes before the first write-start match after reset are dropped (`mem_we` stays 0).
- R4: Once armed, each cycle with `tx_slot` high issues one read at the next address modulo DEPTH. Its data appears on `tx_data` with `tx_valid`=1 three cycles after the slot cycle, and it equals the word the writer placed in that position.
- R5: `tx_valid` and `mem_re` stay 0 until the first map match after reset, whatever `tx_slot` does.
- R6: The fill count is the number of words written but not yet read. A write when the fill count equals DEPTH sets sticky `st_ovf` on the next cycle. The write is still forwarded and the fill count stays at DEPTH.
- R7: A read when the fill count is zero sets sticky `st_udf` on the next cycle. The read is still issued and its word still appears on `tx_data`.
- R8: A pulse on `stat_clr` bit 0 clears `st_ovf`, and a pulse on bit 1 clears `st_udf`. Each clear is seen on the next cycle. A new event in the same cycle as its clear wins, and the bit stays set.
- R9: `cfg_err` is registered. One cycle after any input values it equals 1 exactly when `wstart_ofs` >= `map_ofs`.
- R10: While `rst` is high, and in the first cycle after it falls, `tx_valid`, `mem_re`, `mem_we`, `st_ovf`, `st_udf` and `cfg_err` are 0.
- R11: A write-start match sets the fill count to zero before that cycle's write and read are counted. Words left over from the previous frame therefore cannot cause an overflow in the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pos | input | POS_W | Frame position count from the framer |
| map_ofs | input | POS_W | Position at which reading restarts |
| wstart_ofs | input | POS_W | Position at which writing restarts |
| wr_en | input | 1 | Writer offers a word this cycle |
| wr_data | input | DATA_W | Word offered by the writer |
| tx_slot | input | 1 | Transmitter takes a word this cycle |
| stat_clr | input | 2 | Write-one-to-clear pulses: bit 0 overflow, bit 1 underflow |
| mem_rdata | input | DATA_W | Buffer read data, one cycle after `mem_re` |
| mem_we | output | 1 | Buffer write enable |
| mem_waddr | output | $clog2(DEPTH) | Buffer write address |
| mem_wdata | output | DATA_W | Buffer write data |
| mem_re | output | 1 | Buffer read enable |
| mem_raddr | output | $clog2(DEPTH) | Buffer read address |
| tx_valid | output | 1 | Word on `tx_data` is valid |
| tx_data | output | DATA_W | Word sent to the transmitter |
| tx_k | output | $clog2(K_LEN) | Container index of the word on `tx_data` |
| st_ovf | output | 1 | Sticky overflow flag |
| st_udf | output | 1 | Sticky underflow flag |
| cfg_err | output | 1 | Write-start position not before map position |

## Verification
The bound checker checks several properties on every cycle. A match on either position sends the next buffer access to address zero. No write reaches the RAM before the write side is armed, and no valid word leaves before the first map match. Every read request follows a slot. The status bits hold until their own clear, and they rise only in response to the matching access. The configuration flag follows its comparison with one cycle of delay.

Other behaviour needs a whole frame of stimulus, so only the bench scenarios can show it. These scenarios sweep the map position, force an overflow and an underflow, and race a clear against a setting event. They show the end-to-end pairing of each written word with the output word and its K tag, the exact three-cycle output placement, the K restart across frames, and the fill reset at write start.

// File: rtl/fatx_pkg.sv
package fatx_pkg;

  // bit positions inside stat_clr
  localparam int unsigned CLR_OVF_BIT = 0;
  localparam int unsigned CLR_UDF_BIT = 1;

  typedef struct packed {
    logic udf;
    logic ovf;
  } fatx_stat_t;

  // next value of a sticky bit: a new event beats a clear in the same cycle
  function automatic logic sticky_next(input logic cur, input logic ev, input logic clr);
    return ev | (cur & ~clr);
  endfunction

endpackage

// File: rtl/fatx_offset_cmp.sv
module fatx_offset_cmp #(
  parameter int POS_W = 12
) (
  input  logic [POS_W-1:0] frame_pos,
  input  logic [POS_W-1:0] map_ofs,
  input  logic [POS_W-1:0] wstart_ofs,
  output logic             map_hit,
  output logic             wstart_hit,
  output logic             order_bad
);

  always_comb begin
    map_hit    = (frame_pos == map_ofs);
    wstart_hit = (frame_pos == wstart_ofs);
    // writer must lead the reader inside the frame
    order_bad  = (wstart_ofs >= map_ofs);
  end

endmodule

// File: rtl/fatx_wr_ctrl.sv
module fatx_wr_ctrl #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wstart_hit,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_take,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata
);

  logic          armed_q;
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] wbase;

  always_comb begin
    wr_take = wr_en && (armed_q || wstart_hit);
    wbase   = wstart_hit ? '0 : wptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      wptr_q    <= '0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      if (wstart_hit) armed_q <= 1'b1;
      mem_we <= wr_take;
      if (wr_take) begin
        mem_waddr <= wbase;
        mem_wdata <= wr_data;
        wptr_q    <= wbase + AW'(1);
      end else begin
        wptr_q    <= wbase;
      end
    end
  end

endmodule

// File: rtl/fatx_rd_ctrl.sv
module fatx_rd_ctrl #(
  parameter int DATA_W = 32,
  parameter int AW     = 6,
  parameter int K_LEN  = 16,
  parameter int KW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              map_hit,
  input  logic              tx_slot,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              rd_take,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [KW-1:0]     tx_k
);

  localparam logic [KW-1:0] K_LAST = KW'(K_LEN - 1);

  logic          armed_q;
  logic [AW-1:0] rptr_q;
  logic [AW-1:0] rbase;
  logic [KW-1:0] k_q;
  logic [KW-1:0] kbase;
  logic [KW-1:0] k_s1;
  logic          v_s2;
  logic [KW-1:0] k_s2;

  always_comb begin
    rd_take = tx_slot && (armed_q || map_hit);
    rbase   = map_hit ? '0 : rptr_q;
    kbase   = map_hit ? '0 : k_q;
  end

  // stage 1: pointer, K and the RAM request
  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q   <= 1'b0;
      rptr_q    <= '0;
      k_q       <= '0;
      k_s1      <= '0;
      mem_re    <= 1'b0;
      mem_raddr <= '0;
    end else begin
      if (map_hit) armed_q <= 1'b1;
      mem_re <= rd_take;
      if (rd_take) begin
        mem_raddr <= rbase;
        rptr_q    <= rbase + AW'(1);
        k_s1      <= kbase;
        k_q       <= (kbase == K_LAST) ? '0 : kbase + KW'(1);
      end else begin
        rptr_q    <= rbase;
        k_q       <= kbase;
      end
    end
  end

  // stage 2: wait for RAM data; stage 3: present the word
  always_ff @(posedge clk) begin
    if (rst) begin
      v_s2     <= 1'b0;
      k_s2     <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
      tx_k     <= '0;
    end else begin
      v_s2     <= mem_re;
      if (mem_re) k_s2 <= k_s1;
      tx_valid <= v_s2;
      if (v_s2) begin
        tx_data <= mem_rdata;
        tx_k    <= k_s2;
      end
    end
  end

endmodule

// File: rtl/fatx_fill_track.sv
module fatx_fill_track
  import fatx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int FW    = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wstart_hit,
  input  logic       wr_take,
  input  logic       rd_take,
  input  logic [1:0] stat_clr,
  output fatx_stat_t stat
);

  localparam logic [FW-1:0] FULL = FW'(DEPTH);

  logic [FW-1:0] fill_q;
  logic [FW-1:0] base;
  logic [FW-1:0] after_wr;
  logic [FW-1:0] after_rd;
  logic          ovf_ev;
  logic          udf_ev;

  always_comb begin
    base     = wstart_hit ? '0 : fill_q;
    ovf_ev   = wr_take && (base == FULL);
    udf_ev   = rd_take && (base == '0);
    after_wr = (wr_take && (base != FULL)) ? base + FW'(1) : base;
    after_rd = (rd_take && (after_wr != '0)) ? after_wr - FW'(1) : after_wr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q <= '0;
      stat   <= '0;
    end else begin
      fill_q   <= after_rd;
      stat.ovf <= sticky_next(stat.ovf, ovf_ev, stat_clr[CLR_OVF_BIT]);
      stat.udf <= sticky_next(stat.udf, udf_ev, stat_clr[CLR_UDF_BIT]);
    end
  end

endmodule

// File: rtl/fatx_txbuf_reader.sv
module fatx_txbuf_reader
  import fatx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 64,
  parameter int POS_W  = 12,
  parameter int K_LEN  = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = AW + 1,
  localparam int KW    = (K_LEN > 1) ? $clog2(K_LEN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [POS_W-1:0]  frame_pos,
  input  logic [POS_W-1:0]  map_ofs,
  input  logic [POS_W-1:0]  wstart_ofs,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_slot,
  input  logic [1:0]        stat_clr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_re,
  output logic [AW-1:0]     mem_raddr,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic [KW-1:0]     tx_k,
  output logic              st_ovf,
  output logic              st_udf,
  output logic              cfg_err
);

  initial begin
    if (DEPTH < 2 || (1 << AW) != DEPTH)
      $error("DEPTH must be a power of two of at least 2");
  end

  logic       map_hit;
  logic       wstart_hit;
  logic       order_bad;
  logic       wr_take;
  logic       rd_take;
  fatx_stat_t stat;

  fatx_offset_cmp #(.POS_W(POS_W)) u_cmp (
    .frame_pos  (frame_pos),
    .map_ofs    (map_ofs),
    .wstart_ofs (wstart_ofs),
    .map_hit    (map_hit),
    .wstart_hit (wstart_hit),
    .order_bad  (order_bad)
  );

  fatx_wr_ctrl #(.DATA_W(DATA_W), .AW(AW)) u_wr (
    .clk        (clk),
    .rst        (rst),
    .wstart_hit (wstart_hit),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .wr_take    (wr_take),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata)
  );

  fatx_rd_ctrl #(.DATA_W(DATA_W), .AW(AW), .K_LEN(K_LEN), .KW(KW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .map_hit   (map_hit),
    .tx_slot   (tx_slot),
    .mem_rdata (mem_rdata),
    .rd_take   (rd_take),
    .mem_re    (mem_re),
    .mem_raddr (mem_raddr),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_k      (tx_k)
  );

  fatx_fill_track #(.DEPTH(DEPTH), .FW(FW)) u_fill (
    .clk        (clk),
    .rst        (rst),
    .wstart_hit (wstart_hit),
    .wr_take    (wr_take),
    .rd_take    (rd_take),
    .stat_clr   (stat_clr),
    .stat       (stat)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= order_bad;
  end

  assign st_ovf = stat.ovf;
  assign st_udf = stat.udf;

endmodule

// File: rtl/fatx_txbuf_reader_chk.sv
module fatx_txbuf_reader_chk #(
  parameter int POS_W = 12,
  parameter int AW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic [POS_W-1:0] frame_pos,
  input logic [POS_W-1:0] map_ofs,
  input logic [POS_W-1:0] wstart_ofs,
  input logic             wr_en,
  input logic             tx_slot,
  input logic [1:0]       stat_clr,
  input logic             mem_we,
  input logic [AW-1:0]    mem_waddr,
  input logic             mem_re,
  input logic [AW-1:0]    mem_raddr,
  input logic             tx_valid,
  input logic             st_ovf,
  input logic             st_udf,
  input logic             cfg_err
);

  logic seen_map;
  logic seen_wstart;
  logic live_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_map    <= 1'b0;
      seen_wstart <= 1'b0;
      live_q      <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (frame_pos == map_ofs)    seen_map    <= 1'b1;
      if (frame_pos == wstart_ofs) seen_wstart <= 1'b1;
    end
  end

  assert_rd_origin_R1: assert property (@(posedge clk) disable iff (rst)
    (frame_pos == map_ofs && tx_slot) |=> (mem_re && mem_raddr == '0));

  assert_wr_origin_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_pos == wstart_ofs && wr_en) |=> (mem_we && mem_waddr == '0));

  assert_wr_dropped_R3: assert property (@(posedge clk) disable iff (rst)
    (!seen_wstart && frame_pos != wstart_ofs) |=> !mem_we);

  assert_read_needs_slot_R4: assert property (@(posedge clk) disable iff (rst)
    (live_q && mem_re) |-> $past(tx_slot));

  assert_quiet_before_map_R5: assert property (@(posedge clk) disable iff (rst)
    !seen_map |-> (!tx_valid && !mem_re));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (st_ovf && !stat_clr[0]) |=> st_ovf);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (rst)
    (live_q && $rose(st_ovf)) |-> $past(wr_en));

  assert_udf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (st_udf && !stat_clr[1]) |=> st_udf);

  assert_udf_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (live_q && $rose(st_udf)) |-> $past(tx_slot));

  assert_ovf_clear_R8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr[0] && !wr_en) |=> !st_ovf);

  assert_cfg_flag_R9: assert property (@(posedge clk) disable iff (rst)
    live_q |-> (cfg_err == $past(wstart_ofs >= map_ofs)));

endmodule

bind fatx_txbuf_reader fatx_txbuf_reader_chk #(.POS_W(POS_W), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_pos  (frame_pos),
  .map_ofs    (map_ofs),
  .wstart_ofs (wstart_ofs),
  .wr_en      (wr_en),
  .tx_slot    (tx_slot),
  .stat_clr   (stat_clr),
  .mem_we     (mem_we),
  .mem_waddr  (mem_waddr),
  .mem_re     (mem_re),
  .mem_raddr  (mem_raddr),
  .tx_valid   (tx_valid),
  .st_ovf     (st_ovf),
  .st_udf     (st_udf),
  .cfg_err    (cfg_err)
);

// File: tb/fatx_txbuf_reader_tb.sv
module fatx_txbuf_reader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 8;
  localparam int POS_W  = 6;
  localparam int K_LEN  = 5;
  localparam int AW     = $clog2(DEPTH);
  localparam int KW     = $clog2(K_LEN);
  localparam int FRAME  = 1 << POS_W;
  localparam int WD_CYCLES = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [POS_W-1:0]  frame_pos = '0;
  logic [POS_W-1:0]  map_ofs = '0;
  logic [POS_W-1:0]  wstart_ofs = '0;
  logic              wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              tx_slot = 1'b0;
  logic [1:0]        stat_clr = '0;
  logic [DATA_W-1:0] mem_rdata;
  logic              mem_we;
  logic [AW-1:0]     mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_re;
  logic [AW-1:0]     mem_raddr;
  logic              tx_valid;
  logic [DATA_W-1:0] tx_data;
  logic [KW-1:0]     tx_k;
  logic              st_ovf;
  logic              st_udf;
  logic              cfg_err;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fatx_txbuf_reader #(.DATA_W(DATA_W), .DEPTH(DEPTH), .POS_W(POS_W), .K_LEN(K_LEN)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .frame_pos  (frame_pos),
    .map_ofs    (map_ofs),
    .wstart_ofs (wstart_ofs),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .tx_slot    (tx_slot),
    .stat_clr   (stat_clr),
    .mem_rdata  (mem_rdata),
    .mem_we     (mem_we),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_re     (mem_re),
    .mem_raddr  (mem_raddr),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_k       (tx_k),
    .st_ovf     (st_ovf),
    .st_udf     (st_udf),
    .cfg_err    (cfg_err)
  );

  // simple dual-port buffer RAM, read data one cycle after the request
  logic [DATA_W-1:0] ram [DEPTH];
  always_ff @(posedge clk) begin
    if (mem_we) ram[mem_waddr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_raddr];
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at t=%0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int fr, input int idx);
    return 32'hC0DE_0000 | (DATA_W'(fr) << 8) | DATA_W'(idx);
  endfunction

  function automatic bit in_win(input int p, input int lo, input int hi);
    return (p >= lo) && (p <= hi);
  endfunction

  // One frame of FRAME cycles. At each step the outputs are sampled for
  // position p, then the inputs for position p are driven.
  task automatic run_frame(input int fr, input int m, input int ws, input int nwr,
                           input int nrd, input bit first, input bit chk_data,
                           input int ovf_from, input int udf_from,
                           input int clr0_at, input int clr1_a, input int clr1_b);
    for (int p = 0; p < FRAME; p++) begin
      @(negedge clk);
      // ---- sample ----
      begin
        bit exp_v = in_win(p, m + 3, m + nrd + 2);
        bit exp_o = (ovf_from >= 0) && in_win(p, ovf_from, 40);
        bit exp_u = (udf_from >= 0) && in_win(p, udf_from, 40);
        check(tx_valid == exp_v, "R4 tx_valid placement", tx_valid, exp_v);
        if (exp_v) begin
          int i = p - m - 3;
          check(tx_k == KW'(i % K_LEN), "R2 container index", tx_k, i % K_LEN);
          if (chk_data)
            check(tx_data == pattern(fr, i), "R4 data order", tx_data, pattern(fr, i));
        end
        check(st_ovf == exp_o, "R6/R8 overflow flag", st_ovf, exp_o);
        check(st_udf == exp_u, "R7/R8 underflow flag", st_udf, exp_u);
        if (p == 5)
          check(cfg_err == (ws >= m), "R9 order flag", cfg_err, (ws >= m));
        if (first && (p == 1 || p == 2))
          check(mem_we == 1'b0, "R3 early write dropped", mem_we, 0);
        if (p == ws + 1 && nwr > 0)
          check(mem_we && mem_waddr == '0 && mem_wdata == pattern(fr, 0),
                "R3 write origin", {mem_we, mem_waddr}, {1'b1, AW'(0)});
        if (p == m + 1 && nrd > 0)
          check(mem_re && mem_raddr == '0, "R1 read origin", {mem_re, mem_raddr}, {1'b1, AW'(0)});
        if (p == m + 2 && nrd > 1)
          check(mem_re && mem_raddr == AW'(1), "R1 second read address", mem_raddr, 1);
        if (p == 63 && ovf_from < 0 && udf_from < 0)
          check(!st_ovf && !st_udf, "R11 fill restart", {st_ovf, st_udf}, 0);
      end
      // ---- drive ----
      frame_pos  = POS_W'(p);
      map_ofs    = POS_W'(m);
      wstart_ofs = POS_W'(ws);
      if (in_win(p, ws, ws + nwr - 1)) begin
        wr_en   = 1'b1;
        wr_data = pattern(fr, p - ws);
      end else if (first && p < 2) begin
        wr_en   = 1'b1;
        wr_data = 32'hDEAD_0000 | DATA_W'(p);
      end else begin
        wr_en   = 1'b0;
        wr_data = '0;
      end
      tx_slot     = in_win(p, m, m + nrd - 1);
      stat_clr[0] = (p == clr0_at);
      stat_clr[1] = (p == clr1_a) || (p == clr1_b);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog (all requirements): actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R10: outputs during reset and in the first cycle after it
    repeat (3) @(negedge clk);
    check({tx_valid, mem_re, mem_we, st_ovf, st_udf, cfg_err} == '0,
          "R10 reset state (in reset)", {tx_valid, mem_re, mem_we, st_ovf, st_udf, cfg_err}, 0);
    map_ofs    = POS_W'(6);
    wstart_ofs = POS_W'(2);
    frame_pos  = POS_W'(40);
    rst = 1'b0;
    @(negedge clk);
    check({tx_valid, mem_re, mem_we, st_ovf, st_udf, cfg_err} == '0,
          "R10 reset state (after release)", {tx_valid, mem_re, mem_we, st_ovf, st_udf, cfg_err}, 0);

    // R5: slots offered before any map match produce nothing
    tx_slot = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      check(!tx_valid && !mem_re, "R5 quiet before first match", {tx_valid, mem_re}, 0);
    end
    tx_slot = 1'b0;

    // frames: fr, map, wstart, nwr, nrd, first, data, ovf_from, udf_from, clr0, clr1a, clr1b
    run_frame(0, 6,  2, 22, 22, 1'b1, 1'b1, -1, -1, -1, -1, -1); // R3 early drop, R1, R2, R4
    run_frame(1, 6,  2, 22, 22, 1'b0, 1'b1, -1, -1, -1, -1, -1); // R2 K restart
    run_frame(2, 4,  2, 22, 22, 1'b0, 1'b1, -1, -1, -1, -1, -1); // R4 map sweep
    run_frame(3, 9,  2, 22, 22, 1'b0, 1'b1, -1, -1, -1, -1, -1); // R4 fill of DEPTH-1
    run_frame(4, 10, 2, 22, 21, 1'b0, 1'b0, 11, -1, 40, -1, -1); // R6 overflow, R8 clear
    run_frame(5, 6, 30,  8, 22, 1'b0, 1'b0, -1,  7, -1,  6, 40); // R7 underflow, R8 set wins, R9
    run_frame(6, 6,  2, 22, 22, 1'b0, 1'b1, -1, -1, -1, -1, -1); // R11 fill restart

    // R9: equal positions count as a bad order
    @(negedge clk);
    wstart_ofs = POS_W'(6);
    map_ofs    = POS_W'(6);
    frame_pos  = POS_W'(50);
    @(negedge clk);
    check(cfg_err == 1'b1, "R9 equal positions", cfg_err, 1);
    wstart_ofs = POS_W'(5);
    @(negedge clk);
    check(cfg_err == 1'b0, "R9 strictly before", cfg_err, 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule